// File: doc/BRIEF.md
# SPI register access slave

This block is the serial front end of a clock-calendar device. An external master reaches the device's byte-wide registers through it over a four-wire SPI link: a select line, a serial clock, a data input and a data output. The block oversamples all three serial inputs in the system clock domain and assembles bytes from them. It turns the first byte of every transaction into a direction and a start address. Each later byte becomes one write or one read on a plain parallel register bus.

Transfers may run in bursts. The address steps by one after every data byte, so a master can fetch the whole time-of-day group, or fill a run of general-purpose memory, with a single select pulse. The block owns the address map's holes. Locations outside the control range and the memory window produce no bus cycle at all. Reads from them return zero.

Top module: `spi_regif`

## Requirements
- R1: After reset, `miso_o`, `reg_wr_o` and `reg_rd_o` are 0.
- R2: A transaction runs while `sel_i` is high (active-high select). The link uses SPI mode 3: `sck_i` idles high and `mosi_i` is sampled on its rising edge, MSB first. In the first byte, bit 7 = 1 means write and bit 7 = 0 means read, and bits 6:0 give the start address.
- R3: In a write transaction, every complete data byte produces a `reg_wr_o` pulse that lasts exactly one `clk` cycle, carrying the byte on `reg_wdata_o` and the current address on `reg_addr_o`.
- R4: The address advances by one after every data byte of a burst, wrapping from 0x7F to 0x00. `reg_addr_o` moves in the cycle after a write pulse.
- R5: In a read transaction, `reg_rd_o` pulses for one cycle after the address byte and again after each data byte, for the next address. `reg_rdata_i` is taken in the cycle after the pulse. The byte is shifted out on `miso_o` MSB first and changes only after falling `sck_i` edges.
- R6: Mapped addresses are 0x00 to 0x11 and 0x20 to 0x7F (96 bytes of memory from 0x20). An unmapped write raises no `reg_wr_o`. An unmapped read raises no `reg_rd_o` and returns 0x00.
- R7: Dropping `sel_i` in the middle of a byte discards that byte with no strobe. The next transaction starts again with an address byte.
- R8: `miso_o` is 0 whenever no read data is being shifted: during the address byte, during write transactions, and from three cycles after `sel_i` falls.
- R9: `reg_wr_o` and `reg_rd_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Serial select, active high |
| sck_i | input | 1 | Serial clock, idles high |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| reg_addr_o | output | 7 | Register bus address |
| reg_wdata_o | output | 8 | Register bus write data |
| reg_wr_o | output | 1 | Register bus write strobe, one cycle |
| reg_rd_o | output | 1 | Register bus read strobe, one cycle |
| reg_rdata_i | input | 8 | Register bus read data, valid the cycle after `reg_rd_o` |

## Verification
The bench drives bursts that cross the edges of the map. Runs from 0x10 and from 0x1E straddle the hole; a design with a wrong decode would pulse a strobe there or return stale data instead of zero. A burst starting at 0x7E checks the address wrap, which a design with an 8-bit counter would break by leaving the 7-bit space. Select is dropped part-way through both an address byte and a data byte. A design that did not clear its bit counter would then misframe every following transaction, and one that wrote partial bytes would raise an unexpected strobe. Every read strobe, including the prefetch after the last byte, is matched against a queue of expected addresses, so a wrong read order or an extra fetch is caught.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [0:0] {
        PH_HDR  = 1'b0,
        PH_BODY = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic                is_wr;
        logic [CNT_W-1:0]    bitcnt;
        logic [BYTE_W-2:0]   rx;
        logic [BYTE_W-1:0]   tx;
        logic [ADDR_W-1:0]   addr;
        logic [BYTE_W-1:0]   wdata;
        logic                wr;
        logic                rd;
        logic                fetch;
        logic                ld;
        logic                ldmap;
        logic                inc;
        logic                miso;
        logic                sck_prev;
    } regif_st_t;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES:0]   chain_d;

    always_comb chain_d = {chain_q, d};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d[STAGES-1:0];
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_map_dec.sv
module spi_map_dec #(
    parameter int ADDR_W    = 7,
    parameter int CTRL_LAST = 'h11,
    parameter int MEM_BASE  = 'h20,
    parameter int MEM_LEN   = 96
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int MEM_END = MEM_BASE + MEM_LEN;
    int a;

    always_comb begin
        a   = int'(addr);
        hit = (a <= CTRL_LAST) || ((a >= MEM_BASE) && (a < MEM_END));
    end
endmodule

// File: rtl/spi_regif.sv
module spi_regif
    import spi_regif_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CTRL_LAST   = 'h11,
    parameter int MEM_BASE    = 'h20,
    parameter int MEM_LEN     = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              sck_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [BYTE_W-1:0] reg_wdata_o,
    output logic              reg_wr_o,
    output logic              reg_rd_o,
    input  logic [BYTE_W-1:0] reg_rdata_i
);
    localparam int         N_SYNC   = 3;
    localparam logic [2:0] SYNC_RST = 3'b010;   // {mosi, sck, sel}; clock idles high
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    logic [N_SYNC-1:0] raw_in;
    logic [N_SYNC-1:0] syn_in;
    logic sel_s, sck_s, mosi_s;

    assign raw_in = {mosi_i, sck_i, sel_i};

    for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
        spi_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (SYNC_RST[g])
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_in[g]),
            .q     (syn_in[g])
        );
    end

    assign sel_s  = syn_in[0];
    assign sck_s  = syn_in[1];
    assign mosi_s = syn_in[2];

    regif_st_t st_q, st_d;

    logic [BYTE_W-1:0] byte_full;
    logic [ADDR_W-1:0] addr_nxt;
    logic              hit_cur, hit_nxt, hit_new;
    logic              rise, fall;

    assign byte_full = {st_q.rx, mosi_s};
    assign addr_nxt  = st_q.addr + ADDR_ONE;
    assign rise      = sck_s & ~st_q.sck_prev;
    assign fall      = ~sck_s & st_q.sck_prev;

    spi_map_dec #(.ADDR_W(ADDR_W), .CTRL_LAST(CTRL_LAST), .MEM_BASE(MEM_BASE), .MEM_LEN(MEM_LEN))
        u_dec_cur (.addr(st_q.addr), .hit(hit_cur));
    spi_map_dec #(.ADDR_W(ADDR_W), .CTRL_LAST(CTRL_LAST), .MEM_BASE(MEM_BASE), .MEM_LEN(MEM_LEN))
        u_dec_nxt (.addr(addr_nxt), .hit(hit_nxt));
    spi_map_dec #(.ADDR_W(ADDR_W), .CTRL_LAST(CTRL_LAST), .MEM_BASE(MEM_BASE), .MEM_LEN(MEM_LEN))
        u_dec_new (.addr(byte_full[ADDR_W-1:0]), .hit(hit_new));

    always_comb begin
        st_d          = st_q;
        st_d.wr       = 1'b0;
        st_d.rd       = 1'b0;
        st_d.fetch    = 1'b0;
        st_d.ld       = 1'b0;
        st_d.inc      = 1'b0;
        st_d.sck_prev = sck_s;

        // post-write address step, one cycle after the strobe
        if (st_q.inc) st_d.addr = addr_nxt;

        // read pipeline: strobe -> data valid next cycle -> load shifter
        if (st_q.fetch) begin
            st_d.ld    = 1'b1;
            st_d.ldmap = st_q.rd;
        end
        if (st_q.ld) st_d.tx = st_q.ldmap ? reg_rdata_i : '0;

        if (!sel_s) begin
            st_d.phase  = PH_HDR;
            st_d.bitcnt = '0;
            st_d.miso   = 1'b0;
            st_d.fetch  = 1'b0;
            st_d.ld     = 1'b0;
        end else begin
            if (fall) begin
                st_d.miso = (st_q.phase == PH_BODY && !st_q.is_wr)
                          ? st_q.tx[~st_q.bitcnt] : 1'b0;
            end
            if (rise) begin
                st_d.rx     = byte_full[BYTE_W-2:0];
                st_d.bitcnt = st_q.bitcnt + CNT_W'(1);
                if (st_q.bitcnt == LAST_BIT) begin
                    if (st_q.phase == PH_HDR) begin
                        st_d.phase = PH_BODY;
                        st_d.is_wr = byte_full[BYTE_W-1];
                        st_d.addr  = byte_full[ADDR_W-1:0];
                        if (!byte_full[BYTE_W-1]) begin
                            st_d.rd    = hit_new;
                            st_d.fetch = 1'b1;
                        end
                    end else if (st_q.is_wr) begin
                        st_d.wr    = hit_cur;
                        st_d.wdata = byte_full;
                        st_d.inc   = 1'b1;
                    end else begin
                        st_d.addr  = addr_nxt;
                        st_d.rd    = hit_nxt;
                        st_d.fetch = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.phase    <= PH_HDR;
            st_q.sck_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign miso_o      = st_q.miso;
    assign reg_addr_o  = st_q.addr;
    assign reg_wdata_o = st_q.wdata;
    assign reg_wr_o    = st_q.wr;
    assign reg_rd_o    = st_q.rd;

endmodule

// File: rtl/spi_regif_chk.sv
module spi_regif_chk #(
    parameter int CTRL_LAST = 'h11,
    parameter int MEM_BASE  = 'h20,
    parameter int MEM_LEN   = 96
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sel_i,
    input logic       miso_o,
    input logic [6:0] reg_addr_o,
    input logic       reg_wr_o,
    input logic       reg_rd_o
);
    function automatic logic in_map(input logic [6:0] a);
        return (int'(a) <= CTRL_LAST) ||
               ((int'(a) >= MEM_BASE) && (int'(a) < MEM_BASE + MEM_LEN));
    endfunction

    a_r3_wr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> !reg_wr_o);

    a_r5_rd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_o |=> !reg_rd_o);

    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> reg_addr_o == $past(reg_addr_o) + 7'd1);

    a_r6_wr_mapped: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |-> in_map(reg_addr_o));

    a_r6_rd_mapped: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_o |-> in_map(reg_addr_o));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_o && reg_rd_o));

    a_r8_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_i && !$past(sel_i) && !$past(sel_i, 2) && !$past(sel_i, 3)) |-> !miso_o);

endmodule

bind spi_regif spi_regif_chk #(
    .CTRL_LAST (CTRL_LAST),
    .MEM_BASE  (MEM_BASE),
    .MEM_LEN   (MEM_LEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (sel_i),
    .miso_o     (miso_o),
    .reg_addr_o (reg_addr_o),
    .reg_wr_o   (reg_wr_o),
    .reg_rd_o   (reg_rd_o)
);

// File: tb/spi_regif_tb.sv
module spi_regif_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int GAP        = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_i = 1'b0;
    logic       sck_i = 1'b1;
    logic       mosi_i = 1'b0;
    logic       miso_o;
    logic [6:0] reg_addr_o;
    logic [7:0] reg_wdata_o;
    logic       reg_wr_o, reg_rd_o;
    logic [7:0] reg_rdata_i;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regif u_dut (
        .clk (clk), .rst_n (rst_n), .sel_i (sel_i), .sck_i (sck_i),
        .mosi_i (mosi_i), .miso_o (miso_o), .reg_addr_o (reg_addr_o),
        .reg_wdata_o (reg_wdata_o), .reg_wr_o (reg_wr_o),
        .reg_rd_o (reg_rd_o), .reg_rdata_i (reg_rdata_i)
    );

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0]  rf_mem  [0:127];
    logic [7:0]  exp_mem [0:127];
    logic [14:0] wr_q [$];
    logic [6:0]  rd_q [$];
    logic [7:0]  rx_buf [0:15];

    function automatic logic [7:0] init_val(input int i);
        return 8'(i * 29 + 5);
    endfunction

    function automatic logic mapped(input logic [6:0] a);
        return (a <= 7'h11) || (a >= 7'h20);
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // register file model: write on strobe, read data valid the cycle after
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) rf_mem[i] <= init_val(i);
            reg_rdata_i <= 8'h00;
        end else begin
            if (reg_wr_o) rf_mem[reg_addr_o] <= reg_wdata_o;
            if (reg_rd_o) reg_rdata_i <= rf_mem[reg_addr_o];
        end
    end

    // monitor: pops expected bus cycles as the design produces them
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr_o) begin
                if (reg_rd_o) check(1'b0, "R9", 1, 0);
                if (wr_q.size() == 0) check(1'b0, "R6/R7 unexpected write", int'(reg_addr_o), -1);
                else begin
                    logic [14:0] it;
                    it = wr_q.pop_front();
                    check({reg_addr_o, reg_wdata_o} == it, "R3",
                          int'({reg_addr_o, reg_wdata_o}), int'(it));
                end
            end
            if (reg_rd_o) begin
                if (rd_q.size() == 0) check(1'b0, "R6 unexpected read", int'(reg_addr_o), -1);
                else begin
                    logic [6:0] ra;
                    ra = rd_q.pop_front();
                    check(reg_addr_o == ra, "R5", int'(reg_addr_o), int'(ra));
                end
            end
        end
    end

    task automatic spi_byte(input logic [7:0] b, input int nbits, output logic [7:0] r);
        r = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            sck_i  = 1'b0;
            mosi_i = b[i];
            repeat (HALF) @(negedge clk);
            r[i]  = miso_o;
            sck_i = 1'b1;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic sel_on();
        @(negedge clk);
        sel_i = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic sel_off();
        repeat (HALF) @(negedge clk);
        sel_i = 1'b0;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic drain(input string req);
        check(wr_q.size() == 0, req, wr_q.size(), 0);
        check(rd_q.size() == 0, req, rd_q.size(), 0);
    endtask

    task automatic wr_burst(input logic [6:0] a, input int n, input logic [7:0] base);
        logic [7:0] r;
        sel_on();
        spi_byte({1'b1, a}, 8, r);
        check(r == 8'h00, "R8 header", r, 0);
        for (int k = 0; k < n; k++) begin
            logic [6:0] ak;
            logic [7:0] dk;
            ak = a + 7'(k);
            dk = base + 8'(k);
            if (mapped(ak)) begin
                wr_q.push_back({ak, dk});
                exp_mem[ak] = dk;
            end
            spi_byte(dk, 8, r);
            check(r == 8'h00, "R8 write", r, 0);
        end
        sel_off();
        drain("R3/R4 write burst");
    endtask

    task automatic rd_burst(input logic [6:0] a, input int n, input string req);
        logic [7:0] r;
        for (int k = 0; k <= n; k++) begin
            logic [6:0] ak;
            ak = a + 7'(k);
            if (mapped(ak)) rd_q.push_back(ak);
        end
        sel_on();
        spi_byte({1'b0, a}, 8, r);
        check(r == 8'h00, "R8 header", r, 0);
        for (int k = 0; k < n; k++) begin
            spi_byte(8'hFF, 8, r);
            rx_buf[k] = r;
        end
        sel_off();
        for (int k = 0; k < n; k++) begin
            logic [6:0] ak;
            logic [7:0] ek;
            ak = a + 7'(k);
            ek = mapped(ak) ? exp_mem[ak] : 8'h00;
            check(rx_buf[k] == ek, req, rx_buf[k], ek);
        end
        drain("R5 read strobes");
    endtask

    initial begin
        logic [7:0] r;
        for (int i = 0; i < 128; i++) exp_mem[i] = init_val(i);
        repeat (5) @(negedge clk);
        // R1: reset state
        check(miso_o == 1'b0, "R1 miso", miso_o, 0);
        check(reg_wr_o == 1'b0, "R1 wr", reg_wr_o, 0);
        check(reg_rd_o == 1'b0, "R1 rd", reg_rd_o, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R2 R3 R4: write burst inside the control range
        wr_burst(7'h05, 3, 8'h40);
        // R2 R5: time group read, then alarm group read
        rd_burst(7'h00, 7, "R5 burst from 0x00");
        rd_burst(7'h07, 4, "R5 burst from 0x07");
        // R4: wrap from 0x7F to 0x00
        wr_burst(7'h7E, 3, 8'h90);
        rd_burst(7'h7E, 3, "R4 wrap read");
        // R6: bursts across the hole
        wr_burst(7'h10, 4, 8'hA0);
        rd_burst(7'h10, 4, "R6 unmapped read after control");
        rd_burst(7'h1E, 4, "R6 unmapped read before memory");

        // R7: abort inside a data byte
        sel_on();
        spi_byte(8'h83, 8, r);
        spi_byte(8'h3C, 5, r);
        sel_off();
        drain("R7 data abort");
        rd_burst(7'h03, 1, "R7 value kept");

        // R7: abort inside the address byte, then a clean write
        sel_on();
        spi_byte(8'h85, 4, r);
        sel_off();
        drain("R7 header abort");
        wr_burst(7'h01, 1, 8'h55);
        rd_burst(7'h01, 2, "R7 restart with address");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule